// File: doc/BRIEF.md
# DMA Channel Error Capture

This block collects error reports from up to 64 DMA channels. Each report is a single-cycle pulse that carries a channel number and a ten-bit set of error kinds. The first report that arrives while the block holds nothing is frozen into one 32-bit status word. That word keeps a valid flag, the failing channel's number and the error-kind bits, and it stays unchanged until software releases it.

Independently of that word, every channel has a sticky error flag. Every channel also has an error-interrupt enable. The enables can be loaded as two 32-bit words, and they can also be set or cleared one channel at a time through byte-wide strobe ports. A byte-wide clear-error strobe names a channel and drops that channel's flag. When it names the captured channel, it also releases the status word. The interrupt output is raised while any flagged channel is also enabled.

Error reports are accepted on every cycle, so there is no back-pressure. A pulse is never stalled or dropped, and the block has no ready signal. The read port is a plain combinational select over the status word, the two flag words and the two enable words.

Top module: `dma_err_capture`

## Requirements
- R1: After reset, the status word, all channel flags, all enables and `err_irq` are zero.
- R2: An error pulse that arrives while status bit 31 is clear is captured one cycle later. The captured word has bit 31 = 1, bits 13:8 = channel, bit 15 = `err_kind[9]` (group priority), bit 14 = `err_kind[8]` (channel priority), bits 7:0 = `err_kind[7:0]`, and all other bits 0.
- R3: While bit 31 is set, later error pulses leave the status word unchanged.
- R4: A clear-error strobe whose byte equals the captured channel number zeroes the status word. A strobe that names any other channel leaves the word unchanged. An error pulse in the same cycle as a releasing strobe is captured as the new word.
- R5: An error pulse sets its channel's flag. Flags for channels 31..0 read at `rd_sel`=1 and flags for channels 63..32 read at `rd_sel`=2, with bit n standing for channel n (or n+32).
- R6: A clear-error strobe clears the named channel's flag. If an error pulse for the same channel arrives in the same cycle, the flag stays set.
- R7: `en_wr_lo`/`en_wr_hi` load `en_wdata` into the enables of channels 31..0 or 63..32. The enables read at `rd_sel`=3 and `rd_sel`=4.
- R8: The set-enable and clear-enable byte strobes change one channel's enable. Within a cycle the word write is applied first, then the byte set, then the byte clear, so the clear wins.
- R9: `err_irq` is 1 exactly when some channel has both its flag and its enable set, and it follows the registered state.
- R10: A byte strobe whose value is not below the channel count changes nothing.
- R11: `rd_sel` values 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Error report pulse |
| err_chan | input | 6 | Channel of the report |
| err_kind | input | 10 | Error kinds: 9 group prio, 8 channel prio, 7:0 address/offset/count/sg/bus |
| clr_err_stb | input | 1 | Clear-error strobe |
| clr_err_byte | input | 8 | Channel number for clear-error |
| set_en_stb | input | 1 | Set-enable strobe |
| set_en_byte | input | 8 | Channel number for set-enable |
| clr_en_stb | input | 1 | Clear-enable strobe |
| clr_en_byte | input | 8 | Channel number for clear-enable |
| en_wr_lo | input | 1 | Load enables of channels 31..0 |
| en_wr_hi | input | 1 | Load enables of channels 63..32 |
| en_wdata | input | 32 | Enable word data |
| rd_sel | input | 3 | Read select: 0 status, 1/2 flags, 3/4 enables |
| rd_data | output | 32 | Selected register |
| err_irq | output | 1 | Error interrupt |

## Verification
A directed phase first captures an error with every kind bit set. It then sends a second error on another channel, which shows whether the first word is held. After that it releases the word with a wrong channel number and then with the right one, in the same cycle as a new pulse, which separates release from recapture. Same-cycle flag set/clear, set/clear enable and out-of-range bytes then test the orderings. A long random phase uses channel bytes up to 79, so that in-range and ignored strobes mix with collisions. Every cycle all eight read selects and the interrupt are compared with a behavioural model.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;
  localparam int CH_FIELD_W = 6;   // width of channel number in status word
  localparam int KIND_W     = 10;  // error kinds carried by a report
  localparam int WORD_W     = 32;

  // Build a captured status word: valid, priority kinds, channel, other kinds
  function automatic logic [WORD_W-1:0] pack_status(
    input logic [CH_FIELD_W-1:0] ch,
    input logic [KIND_W-1:0]     kind
  );
    return {1'b1, 15'd0, kind[9:8], ch, kind[7:0]};
  endfunction
endpackage

// File: rtl/dma_err_status_word.sv
module dma_err_status_word
  import dma_err_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hit_fire,
  input  logic [CH_FIELD_W-1:0] hit_chan,
  input  logic [KIND_W-1:0]     hit_kind,
  input  logic                  rel_fire,
  input  logic [CH_FIELD_W-1:0] rel_chan,
  output logic [WORD_W-1:0]     status_q
);
  logic held, release_now, free_slot;

  assign held        = status_q[31];
  assign release_now = held && rel_fire && (rel_chan == status_q[8 +: CH_FIELD_W]);
  assign free_slot   = !held || release_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status_q <= '0;
    else if (hit_fire && free_slot)
      status_q <= pack_status(hit_chan, hit_kind);
    else if (release_now)
      status_q <= '0;
  end
endmodule

// File: rtl/dma_err_chan_vec.sv
module dma_err_chan_vec
  import dma_err_pkg::*;
#(
  parameter int NCH = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  err_fire,
  input  logic [CH_FIELD_W-1:0] err_idx,
  input  logic                  clr_fire,
  input  logic [CH_FIELD_W-1:0] clr_idx,
  input  logic                  sen_fire,
  input  logic [CH_FIELD_W-1:0] sen_idx,
  input  logic                  cen_fire,
  input  logic [CH_FIELD_W-1:0] cen_idx,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [31:0]           wdata,
  output logic [NCH-1:0]        flags_q,
  output logic [NCH-1:0]        en_q
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [CH_FIELD_W-1:0] IDX = CH_FIELD_W'(g);
    localparam bit UPPER = (g >= 32);
    logic en_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags_q[g] <= 1'b0;
      else if (err_fire && err_idx == IDX)
        flags_q[g] <= 1'b1;
      else if (clr_fire && clr_idx == IDX)
        flags_q[g] <= 1'b0;
    end

    always_comb begin
      en_nxt = en_q[g];
      if (UPPER ? wr_hi : wr_lo) en_nxt = wdata[g % 32];
      if (sen_fire && sen_idx == IDX) en_nxt = 1'b1;
      if (cen_fire && cen_idx == IDX) en_nxt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[g] <= 1'b0;
      else        en_q[g] <= en_nxt;
    end
  end
endmodule

// File: rtl/dma_err_rdmux.sv
module dma_err_rdmux (
  input  logic [2:0]  sel,
  input  logic [31:0] status,
  input  logic [63:0] flags,
  input  logic [63:0] enables,
  output logic [31:0] data
);
  always_comb begin
    case (sel)
      3'd0:    data = status;
      3'd1:    data = flags[31:0];
      3'd2:    data = flags[63:32];
      3'd3:    data = enables[31:0];
      3'd4:    data = enables[63:32];
      default: data = '0;
    endcase
  end
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
  import dma_err_pkg::*;
#(
  parameter int NCH = 64  // 1..64: status word holds a 6-bit channel
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        err_valid,
  input  logic [5:0]  err_chan,
  input  logic [9:0]  err_kind,
  input  logic        clr_err_stb,
  input  logic [7:0]  clr_err_byte,
  input  logic        set_en_stb,
  input  logic [7:0]  set_en_byte,
  input  logic        clr_en_stb,
  input  logic [7:0]  clr_en_byte,
  input  logic        en_wr_lo,
  input  logic        en_wr_hi,
  input  logic [31:0] en_wdata,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        err_irq
);
  logic err_ok, clr_ok, sen_ok, cen_ok;
  logic [WORD_W-1:0] status_w;
  logic [NCH-1:0]    flags_w, en_w;
  logic [63:0]       flags_pad, en_pad;

  // channel numbers at or above NCH are dropped
  assign err_ok = err_valid   && (32'(err_chan)     < NCH);
  assign clr_ok = clr_err_stb && (32'(clr_err_byte) < NCH);
  assign sen_ok = set_en_stb  && (32'(set_en_byte)  < NCH);
  assign cen_ok = clr_en_stb  && (32'(clr_en_byte)  < NCH);

  dma_err_status_word u_word (
    .clk(clk), .rst_n(rst_n),
    .hit_fire(err_ok), .hit_chan(err_chan), .hit_kind(err_kind),
    .rel_fire(clr_ok), .rel_chan(clr_err_byte[5:0]),
    .status_q(status_w)
  );

  dma_err_chan_vec #(.NCH(NCH)) u_vec (
    .clk(clk), .rst_n(rst_n),
    .err_fire(err_ok), .err_idx(err_chan),
    .clr_fire(clr_ok), .clr_idx(clr_err_byte[5:0]),
    .sen_fire(sen_ok), .sen_idx(set_en_byte[5:0]),
    .cen_fire(cen_ok), .cen_idx(clr_en_byte[5:0]),
    .wr_lo(en_wr_lo), .wr_hi(en_wr_hi), .wdata(en_wdata),
    .flags_q(flags_w), .en_q(en_w)
  );

  assign flags_pad = 64'(flags_w);
  assign en_pad    = 64'(en_w);
  assign err_irq   = |(flags_w & en_w);

  dma_err_rdmux u_rd (
    .sel(rd_sel), .status(status_w), .flags(flags_pad), .enables(en_pad),
    .data(rd_data)
  );
endmodule

// File: rtl/dma_err_capture_chk.sv
module dma_err_capture_chk #(
  parameter int NCH = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        err_valid,
  input logic [5:0]  err_chan,
  input logic [9:0]  err_kind,
  input logic        clr_err_stb,
  input logic [7:0]  clr_err_byte,
  input logic        set_en_stb,
  input logic [7:0]  set_en_byte,
  input logic        clr_en_stb,
  input logic [7:0]  clr_en_byte,
  input logic [31:0] status_q,
  input logic [63:0] flags_q,
  input logic [63:0] en_q,
  input logic        err_irq
);
  logic rel_hit;
  assign rel_hit = status_q[31] && clr_err_stb && (clr_err_byte == {2'b00, status_q[13:8]});

  // R2
  capture_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && (32'(err_chan) < NCH) && !status_q[31] |=>
      status_q[31] && status_q[13:8] == $past(err_chan) &&
      status_q[15:14] == $past(err_kind[9:8]) && status_q[7:0] == $past(err_kind[7:0]));

  // R3
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[31] && !rel_hit |=> $stable(status_q));

  // R4
  release_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_hit && !err_valid |=> status_q == 32'd0);

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && (32'(err_chan) < NCH) |=> flags_q[$past(err_chan)]);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err_stb && (32'(clr_err_byte) < NCH) &&
    !(err_valid && {2'b00, err_chan} == clr_err_byte) |=> !flags_q[$past(clr_err_byte[5:0])]);

  // R8
  enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en_stb && (32'(set_en_byte) < NCH) &&
    !(clr_en_stb && clr_en_byte == set_en_byte) |=> en_q[$past(set_en_byte[5:0])]);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (flags_q & en_q) != 64'd0);
endmodule

bind dma_err_capture dma_err_capture_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .err_valid(err_valid), .err_chan(err_chan), .err_kind(err_kind),
  .clr_err_stb(clr_err_stb), .clr_err_byte(clr_err_byte),
  .set_en_stb(set_en_stb), .set_en_byte(set_en_byte),
  .clr_en_stb(clr_en_stb), .clr_en_byte(clr_en_byte),
  .status_q(status_w), .flags_q(flags_pad), .en_q(en_pad), .err_irq(err_irq)
);

// File: tb/dma_err_capture_test.sv
module dma_err_capture_test;
  localparam int NCH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0;
  logic [5:0]  err_chan = '0;
  logic [9:0]  err_kind = '0;
  logic        clr_err_stb = 1'b0;
  logic [7:0]  clr_err_byte = '0;
  logic        set_en_stb = 1'b0;
  logic [7:0]  set_en_byte = '0;
  logic        clr_en_stb = 1'b0;
  logic [7:0]  clr_en_byte = '0;
  logic        en_wr_lo = 1'b0;
  logic        en_wr_hi = 1'b0;
  logic [31:0] en_wdata = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        err_irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_stat = '0;
  logic [63:0] m_flags = '0;
  logic [63:0] m_en = '0;

  always #10 clk = ~clk;  // 50 MHz

  dma_err_capture #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n),
    .err_valid(err_valid), .err_chan(err_chan), .err_kind(err_kind),
    .clr_err_stb(clr_err_stb), .clr_err_byte(clr_err_byte),
    .set_en_stb(set_en_stb), .set_en_byte(set_en_byte),
    .clr_en_stb(clr_en_stb), .clr_en_byte(clr_en_byte),
    .en_wr_lo(en_wr_lo), .en_wr_hi(en_wr_hi), .en_wdata(en_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .err_irq(err_irq)
  );

  // behavioural reference, updated at each rising edge from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = '0; m_flags = '0; m_en = '0;  // R1
    end else begin
      logic [31:0] ns;
      logic [63:0] nf, ne;
      int cb, sb, kb;
      cb = int'(clr_err_byte); sb = int'(set_en_byte); kb = int'(clr_en_byte);
      // R6 / R10
      nf = m_flags;
      if (clr_err_stb && cb < NCH) nf[cb] = 1'b0;
      if (err_valid) nf[int'(err_chan)] = 1'b1;
      // R4 / R2 / R3
      ns = m_stat;
      if (m_stat[31] && clr_err_stb && cb == int'(m_stat[13:8])) ns = '0;
      if (err_valid && !ns[31]) begin
        ns = '0;
        ns[31] = 1'b1; ns[15] = err_kind[9]; ns[14] = err_kind[8];
        ns[13:8] = err_chan; ns[7:0] = err_kind[7:0];
      end
      // R7 / R8
      ne = m_en;
      if (en_wr_lo) ne[31:0] = en_wdata;
      if (en_wr_hi) ne[63:32] = en_wdata;
      if (set_en_stb && sb < NCH) ne[sb] = 1'b1;
      if (clr_en_stb && kb < NCH) ne[kb] = 1'b0;
      m_stat = ns; m_flags = nf; m_en = ne;
    end
  end

  function automatic string tag_of(int s, bit in_reset);
    if (in_reset) return "R1";
    case (s)
      0:       return "R2 R3 R4";
      1, 2:    return "R5 R6 R10";
      3, 4:    return "R7 R8 R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(int s);
    case (s)
      0: return m_stat;
      1: return m_flags[31:0];
      2: return m_flags[63:32];
      3: return m_en[31:0];
      4: return m_en[63:32];
      default: return 32'd0;
    endcase
  endfunction

  // compare every register view and the interrupt on each falling edge
  always @(negedge clk) begin
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      #1;
      compared++;
      if (rd_data !== exp_read(s)) begin
        mismatched++;
        $display("FAIL %s sel=%0d actual=%h expected=%h t=%0t",
                 tag_of(s, !rst_n), s, rd_data, exp_read(s), $time);
      end
    end
    compared++;
    if (err_irq !== (|(m_flags & m_en))) begin
      mismatched++;
      $display("FAIL %s irq actual=%b expected=%b t=%0t",
               rst_n ? "R9" : "R1", err_irq, |(m_flags & m_en), $time);
    end
  end

  task automatic tick();
    @(negedge clk); #9;
    err_valid = 0; clr_err_stb = 0; set_en_stb = 0; clr_en_stb = 0;
    en_wr_lo = 0; en_wr_hi = 0;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;              // R1 checked during and right after reset
    idle(2);
    // R2: capture with all kind bits
    tick(); err_valid = 1; err_chan = 6'd5; err_kind = 10'h3FF;
    idle(1);
    // R3: second error on another channel, word held; R5 flag 40
    tick(); err_valid = 1; err_chan = 6'd40; err_kind = 10'h001;
    idle(1);
    // R4: wrong channel does not release; R6 clears flag 40
    tick(); clr_err_stb = 1; clr_err_byte = 8'd40;
    idle(1);
    // R4: release with capture in same cycle
    tick(); clr_err_stb = 1; clr_err_byte = 8'd5;
            err_valid = 1; err_chan = 6'd9; err_kind = 10'h281;
    idle(1);
    // R6: same-cycle set and clear of one flag keeps it
    tick(); clr_err_stb = 1; clr_err_byte = 8'd12; err_valid = 1; err_chan = 6'd12;
    idle(1);
    // R7: word writes
    tick(); en_wr_lo = 1; en_wr_hi = 1; en_wdata = 32'h0000_1000;
    idle(1);
    // R8: set and clear same channel, clear wins over word and set
    tick(); en_wr_lo = 1; en_wdata = 32'hFFFF_FFFF;
            set_en_stb = 1; set_en_byte = 8'd3; clr_en_stb = 1; clr_en_byte = 8'd3;
    idle(1);
    // R9: enable 63 then flag it
    tick(); set_en_stb = 1; set_en_byte = 8'd63;
    tick(); err_valid = 1; err_chan = 6'd63; err_kind = 10'h010;
    idle(1);
    // R10: out-of-range bytes ignored
    tick(); clr_err_stb = 1; clr_err_byte = 8'd127; clr_en_stb = 1; clr_en_byte = 8'd200;
            set_en_stb = 1; set_en_byte = 8'd64;
    idle(1);
    // random mixture
    for (int i = 0; i < 3000; i++) begin
      tick();
      err_valid    = ($urandom_range(0, 3) == 0);
      err_chan     = 6'($urandom_range(0, 63));
      err_kind     = 10'($urandom);
      clr_err_stb  = ($urandom_range(0, 3) == 0);
      clr_err_byte = ($urandom_range(0, 1) == 0) ? m_stat[13:8] : 8'($urandom_range(0, 79));
      set_en_stb   = ($urandom_range(0, 3) == 0);
      set_en_byte  = 8'($urandom_range(0, 79));
      clr_en_stb   = ($urandom_range(0, 3) == 0);
      clr_en_byte  = 8'($urandom_range(0, 79));
      en_wr_lo     = ($urandom_range(0, 15) == 0);
      en_wr_hi     = ($urandom_range(0, 15) == 0);
      en_wdata     = $urandom;
    end
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule